// File: doc/BRIEF.md
# Calendar Clock with Update-in-Progress Flag

This block keeps the time of day and the calendar for a system: seconds, minutes, hours, day of the week, day of the month, month, a two-digit year and a century byte. A one-second rollover comes from a prescaler that counts enable pulses of a 32.768 kHz time base. On the rollover edge every field that needs to change advances in the same clock cycle. The carry passes from seconds through to the century. A short table of month lengths limits the day of the month, and February has 29 days in every year whose two-digit value is a multiple of four.

The number format is chosen at run time. One control input selects binary or packed BCD for every field, and another selects a 24-hour or a 12-hour clock. The stored bytes are not converted when the format changes. They are read in whatever format is selected when the next rollover happens. A status output goes high during the last few time-base ticks before each rollover so that software can avoid reading a value that is about to change. A one-cycle event marks each completed rollover.

A freeze input stops the time from advancing while software loads new values through a byte-wide field write port. A three-bit divider control can stop the prescaler or hold it in reset. When the divider leaves reset, the first rollover comes half a second later.

Top module: `cal_clock`

## Requirements
- R1: After reset the fields read sec=0, min=0, hour=0, day of week=1, day of month=1, month=1, year=0 and century=0, with `uip` and `updEnd` both low.
- R2: On each rollover the seconds count 0..59. Carries ripple into the minutes (0..59) and then the hours (0..23 in 24-hour mode), and all of them update in the same cycle.
- R3: When the hour wraps, the day of the month advances. It returns to 1 after the last day of the month: 30 days for months 4, 6, 9 and 11, 31 days for the other months, and 29 days for February when year mod 4 is 0 (otherwise 28). The month then steps through 1..12 and the year through 0..99, and each wrap of the year increments the century (which wraps 99 to 0).
- R4: With `binMode`=1 every field holds a plain binary value. With `binMode`=0 every field holds packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R5: With `hour24`=0 the hours byte holds 12, 1..11 in bits 6:0, and bit 7 = 1 marks PM. The sequence is 11 PM to 12 AM, then 11 AM to 12 PM.
- R6: The day of the week counts 1..7 and wraps 7 to 1 when the hour wraps.
- R7: `uip` is high exactly while the clock is running and the prescaler is in its last UIP_TICKS counts before the rollover. It is therefore high in the cycle just before every `updEnd`.
- R8: `updEnd` is a one-cycle pulse in the cycle in which the new time first appears on the outputs.
- R9: While `setMode`=1 the fields do not advance, `updEnd` stays low and `uip` stays low.
- R10: The clock runs only when `divCtl` is 2 or less. Values 3..5 stop the prescaler. A value of 6 or 7 holds the prescaler at half a second, so the first `updEnd` arrives TICKS_PER_SEC/2 ticks after `divCtl` returns to 2 or less.
- R11: `wrEn`=1 loads `wrData` into the field chosen by `wrSel` (0 sec, 1 min, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year, 7 century), and the new value is visible in the next cycle. A write in a rollover cycle takes priority, and that rollover is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable per time-base period |
| setMode | input | 1 | Freeze the time fields |
| divCtl | input | 3 | Divider control: 0..2 run, 3..5 stop, 6..7 reset |
| binMode | input | 1 | 1 = binary fields, 0 = packed BCD |
| hour24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| wrEn | input | 1 | Field write strobe |
| wrSel | input | 3 | Field index for a write |
| wrData | input | 8 | Field write value |
| secOut | output | 8 | Seconds |
| minOut | output | 8 | Minutes |
| hourOut | output | 8 | Hours |
| dowOut | output | 8 | Day of week |
| domOut | output | 8 | Day of month |
| monOut | output | 8 | Month |
| yearOut | output | 8 | Two-digit year |
| centOut | output | 8 | Century |
| uip | output | 1 | Rollover is imminent |
| updEnd | output | 1 | Rollover has just completed |

## Verification
The rollover is tested from starting points that each exercise a different carry path:
- A BCD 24-hour year-end crossing. It moves every field at once, including the century and the day-of-week wrap.
- A binary 12-hour midnight in a leap February. It separates the Feb 29 rule and the PM-to-AM change.
- A binary 24-hour Feb 28 in a non-leap year. It shows that the month ends early.
- A BCD 12-hour noon on April 30. It checks the 30-day month and the AM-to-PM change.

The freeze case and the stopped-divider case are checked for the absence of any event and for unchanged fields. Release from divider reset is timed cycle by cycle. This separates the half-second start from a restart at zero and also places the status window correctly.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

  localparam int NUM_FIELDS = 8;
  localparam int FIELD_W    = 8;

  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_DOW  = 3;
  localparam int FLD_DOM  = 4;
  localparam int FLD_MON  = 5;
  localparam int FLD_YEAR = 6;
  localparam int FLD_CENT = 7;

  typedef struct packed {
    logic roll;   // advance the calendar on this edge
    logic load;   // field write on this edge
  } ctrlStrobes_t;

  // stored byte -> binary value
  function automatic logic [6:0] decodeVal(input logic [7:0] raw, input logic binMode);
    if (binMode) return raw[6:0];
    return 7'(raw[7:4]) * 7'd10 + 7'(raw[3:0]);
  endfunction

  // binary value -> stored byte
  function automatic logic [7:0] encodeVal(input logic [6:0] val, input logic binMode);
    if (binMode) return {1'b0, val};
    return {4'(val / 7'd10), 4'(val % 7'd10)};
  endfunction

  function automatic logic [6:0] monthLen(input logic [6:0] month, input logic [1:0] yearLow);
    case (month)
      7'd2:                     return (yearLow == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
      default:                  return 7'd31;
    endcase
  endfunction

  function automatic logic [7:0] resetVal(input int idx);
    if (idx == FLD_DOW || idx == FLD_DOM || idx == FLD_MON) return 8'd1;
    return 8'd0;
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import calclk_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         setMode,
  input  logic [2:0]   divCtl,
  input  logic         wrEn,
  output ctrlStrobes_t strb,
  output logic         uip,
  output logic         updEnd
);

  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST_C  = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF_C  = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] UIP_C   = CW'(TICKS_PER_SEC - UIP_TICKS);

  logic [CW-1:0] preCnt;
  logic          divReset;
  logic          divRun;
  logic          running;
  logic          atLast;

  assign divReset = (divCtl[2:1] == 2'b11);
  assign divRun   = (divCtl <= 3'd2);
  assign running  = divRun && !setMode;
  assign atLast   = (preCnt == LAST_C);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (divReset) begin
      preCnt <= HALF_C;
    end else if (divRun && tick) begin
      preCnt <= atLast ? '0 : preCnt + 1'b1;
    end
  end

  always_comb begin
    strb.roll = running && tick && atLast && !wrEn;
    strb.load = wrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) updEnd <= 1'b0;
    else       updEnd <= strb.roll;
  end

  assign uip = running && (preCnt >= UIP_C);

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import calclk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic               binMode,
  input  logic               hour24,
  input  logic [2:0]         wrSel,
  input  logic [FIELD_W-1:0] wrData,
  output logic [FIELD_W-1:0] fldOut [NUM_FIELDS]
);

  logic [FIELD_W-1:0] fld [NUM_FIELDS];
  logic [FIELD_W-1:0] nxt [NUM_FIELDS];

  logic [6:0] curSec, curMin, curHour, curDow, curDom, curMon, curYear, curCent;
  logic [6:0] hourBase;
  logic [6:0] newSec, newMin, newHour, newDow, newDom, newMon, newYear, newCent;
  logic [6:0] hour12;
  logic [7:0] hourEnc;
  logic       cSec, cMin, cHour, cDom, cMon, cYear;

  // decode current values
  always_comb begin
    curSec   = decodeVal(fld[FLD_SEC], binMode);
    curMin   = decodeVal(fld[FLD_MIN], binMode);
    hourBase = decodeVal({1'b0, fld[FLD_HOUR][6:0]}, binMode);
    if (hour24) curHour = hourBase;
    else        curHour = (hourBase % 7'd12) + (fld[FLD_HOUR][7] ? 7'd12 : 7'd0);
    curDow   = decodeVal(fld[FLD_DOW], binMode);
    curDom   = decodeVal(fld[FLD_DOM], binMode);
    curMon   = decodeVal(fld[FLD_MON], binMode);
    curYear  = decodeVal(fld[FLD_YEAR], binMode);
    curCent  = decodeVal(fld[FLD_CENT], binMode);
  end

  // ripple carry through all fields
  always_comb begin
    cSec    = (curSec >= 7'd59);
    newSec  = cSec ? 7'd0 : curSec + 7'd1;
    cMin    = cSec && (curMin >= 7'd59);
    newMin  = cSec ? (cMin ? 7'd0 : curMin + 7'd1) : curMin;
    cHour   = cMin && (curHour >= 7'd23);
    newHour = cMin ? (cHour ? 7'd0 : curHour + 7'd1) : curHour;
    newDow  = cHour ? ((curDow >= 7'd7) ? 7'd1 : curDow + 7'd1) : curDow;
    cDom    = cHour && (curDom >= monthLen(curMon, curYear[1:0]));
    newDom  = cHour ? (cDom ? 7'd1 : curDom + 7'd1) : curDom;
    cMon    = cDom && (curMon >= 7'd12);
    newMon  = cDom ? (cMon ? 7'd1 : curMon + 7'd1) : curMon;
    cYear   = cMon && (curYear >= 7'd99);
    newYear = cMon ? (cYear ? 7'd0 : curYear + 7'd1) : curYear;
    newCent = cYear ? ((curCent >= 7'd99) ? 7'd0 : curCent + 7'd1) : curCent;
  end

  // encode next values
  always_comb begin
    hour12 = ((newHour % 7'd12) == 7'd0) ? 7'd12 : (newHour % 7'd12);
    if (hour24) begin
      hourEnc = encodeVal(newHour, binMode);
    end else begin
      hourEnc = encodeVal(hour12, binMode);
      hourEnc[7] = (newHour >= 7'd12);
    end
    nxt[FLD_SEC]  = encodeVal(newSec, binMode);
    nxt[FLD_MIN]  = encodeVal(newMin, binMode);
    nxt[FLD_HOUR] = hourEnc;
    nxt[FLD_DOW]  = encodeVal(newDow, binMode);
    nxt[FLD_DOM]  = encodeVal(newDom, binMode);
    nxt[FLD_MON]  = encodeVal(newMon, binMode);
    nxt[FLD_YEAR] = encodeVal(newYear, binMode);
    nxt[FLD_CENT] = encodeVal(newCent, binMode);
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rstN) begin
        fld[i] <= resetVal(i);
      end else if (strb.load && (int'(wrSel) == i)) begin
        fld[i] <= wrData;
      end else if (strb.roll) begin
        fld[i] <= nxt[i];
      end
    end
    assign fldOut[i] = fld[i];
  end

endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import calclk_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       setMode,
  input  logic [2:0] divCtl,
  input  logic       binMode,
  input  logic       hour24,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic [7:0] wrData,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [7:0] dowOut,
  output logic [7:0] domOut,
  output logic [7:0] monOut,
  output logic [7:0] yearOut,
  output logic [7:0] centOut,
  output logic       uip,
  output logic       updEnd
);

  ctrlStrobes_t       strb;
  logic [FIELD_W-1:0] fields [NUM_FIELDS];

  cal_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .UIP_TICKS    (UIP_TICKS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .setMode(setMode),
    .divCtl (divCtl),
    .wrEn   (wrEn),
    .strb   (strb),
    .uip    (uip),
    .updEnd (updEnd)
  );

  cal_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .binMode(binMode),
    .hour24 (hour24),
    .wrSel  (wrSel),
    .wrData (wrData),
    .fldOut (fields)
  );

  assign secOut  = fields[FLD_SEC];
  assign minOut  = fields[FLD_MIN];
  assign hourOut = fields[FLD_HOUR];
  assign dowOut  = fields[FLD_DOW];
  assign domOut  = fields[FLD_DOM];
  assign monOut  = fields[FLD_MON];
  assign yearOut = fields[FLD_YEAR];
  assign centOut = fields[FLD_CENT];

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk (
  input logic       clk,
  input logic       rstN,
  input logic       setMode,
  input logic [2:0] divCtl,
  input logic       wrEn,
  input logic [7:0] secOut,
  input logic       uip,
  input logic       updEnd
);

  a_r9_set_clears_uip: assert property (@(posedge clk) disable iff (!rstN)
    setMode |-> !uip);

  a_r9_set_freezes_sec: assert property (@(posedge clk) disable iff (!rstN)
    (setMode && !wrEn) |=> $stable(secOut));

  a_r9_set_blocks_event: assert property (@(posedge clk) disable iff (!rstN)
    setMode |=> !updEnd);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    updEnd |=> !updEnd);

  a_r7_uip_precedes: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updEnd) |-> $past(uip));

  a_r10_reset_blocks_event: assert property (@(posedge clk) disable iff (!rstN)
    (divCtl[2:1] == 2'b11) |=> !updEnd);

endmodule

bind cal_clock cal_clock_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .setMode(setMode),
  .divCtl (divCtl),
  .wrEn   (wrEn),
  .secOut (secOut),
  .uip    (uip),
  .updEnd (updEnd)
);

// File: tb/sim_cal_clock.sv
`timescale 1ns/1ps
module sim_cal_clock;

  localparam int TPS  = 16;
  localparam int UIPT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic setMode = 1'b1;
  logic [2:0] divCtl = 3'd2;
  logic binMode = 1'b0;
  logic hour24 = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic [7:0] secOut, minOut, hourOut, dowOut, domOut, monOut, yearOut, centOut;
  logic uip, updEnd;

  int total = 0;
  int bad = 0;
  logic [63:0] expQ[$];
  string tagQ[$];

  // model state (binary, hour 0..23)
  int mS, mM, mH, mDw, mDm, mMo, mY, mC;

  always #4 clk = ~clk;

  cal_clock #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .setMode(setMode), .divCtl(divCtl),
    .binMode(binMode), .hour24(hour24), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .dowOut(dowOut),
    .domOut(domOut), .monOut(monOut), .yearOut(yearOut), .centOut(centOut),
    .uip(uip), .updEnd(updEnd)
  );

  function automatic logic [7:0] enc(int v);
    if (binMode) return 8'(v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] encHour(int h);
    int h12;
    if (hour24) return enc(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return enc(h12) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic logic [63:0] snapshot();
    return {enc(mC), enc(mY), enc(mMo), enc(mDm), enc(mDw), encHour(mH), enc(mM), enc(mS)};
  endfunction

  function automatic logic [63:0] dutVec();
    return {centOut, yearOut, monOut, domOut, dowOut, hourOut, minOut, secOut};
  endfunction

  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic modelStep();
    mS++;
    if (mS == 60) begin
      mS = 0; mM++;
      if (mM == 60) begin
        mM = 0; mH++;
        if (mH == 24) begin
          mH = 0;
          mDw = (mDw == 7) ? 1 : mDw + 1;
          mDm++;
          if (mDm > mlen(mMo, mY)) begin
            mDm = 1; mMo++;
            if (mMo == 13) begin
              mMo = 1; mY++;
              if (mY == 100) begin mY = 0; mC = (mC == 99) ? 0 : mC + 1; end
            end
          end
        end
      end
    end
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushSteps(int n, string tag);
    for (int k = 0; k < n; k++) begin
      modelStep();
      expQ.push_back(snapshot());
      tagQ.push_back(tag);
    end
  endtask

  task automatic writeField(int sel, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'(sel); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // load model time, freeze, write all fields, release
  task automatic loadTime(int s, int m, int h, int dw, int dm, int mo, int y, int c,
                          logic bin, logic h24);
    @(negedge clk);
    setMode = 1'b1; binMode = bin; hour24 = h24;
    mS = s; mM = m; mH = h; mDw = dw; mDm = dm; mMo = mo; mY = y; mC = c;
    writeField(0, enc(mS));
    writeField(1, enc(mM));
    writeField(2, encHour(mH));
    writeField(3, enc(mDw));
    writeField(4, enc(mDm));
    writeField(5, enc(mMo));
    writeField(6, enc(mY));
    writeField(7, enc(mC));
    @(posedge clk); #2;
    check("R11 field load", dutVec(), snapshot());
    @(negedge clk);
    setMode = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(posedge clk);
    @(posedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rstN && updEnd) begin
        if (expQ.size() == 0) begin
          total++; bad++;
          $display("FAIL R9/R10 unexpected update actual=%h expected=none", dutVec());
        end else begin
          logic [63:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, dutVec(), e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] held;
    logic uipSeen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
    // R1 reset state
    check("R1 reset fields", dutVec(), {8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0});
    check("R1 reset flags", {62'd0, uip, updEnd}, 64'd0);

    // R2 R3 R4 R6: BCD 24h year end, day of week 7 -> 1, century carry
    loadTime(58, 59, 23, 7, 31, 12, 99, 19, 1'b0, 1'b1);
    pushSteps(3, "R2/R3/R4/R6 bcd year end");
    drain();

    // R3 R5: binary 12h, leap Feb 28 11PM -> 12AM Feb 29
    loadTime(59, 59, 23, 3, 28, 2, 24, 20, 1'b1, 1'b0);
    pushSteps(2, "R3/R5 binary 12h leap");
    drain();

    // R3: non-leap Feb 28 -> Mar 1, binary 24h
    loadTime(59, 59, 23, 6, 28, 2, 23, 20, 1'b1, 1'b1);
    pushSteps(2, "R3 non-leap feb");
    drain();

    // R3 R5: BCD 12h, Apr 30 11:59:59 AM -> 12 PM, 30-day month
    loadTime(59, 59, 11, 2, 30, 4, 25, 20, 1'b0, 1'b0);
    pushSteps(1, "R5 noon");
    drain();
    loadTime(59, 59, 23, 2, 30, 4, 25, 20, 1'b0, 1'b0);
    pushSteps(1, "R3 thirty-day month");
    drain();

    // R9: freeze for three seconds
    @(negedge clk);
    setMode = 1'b1;
    @(posedge clk); #2;
    held = dutVec();
    uipSeen = 1'b0;
    for (int k = 0; k < 3 * TPS; k++) begin
      @(posedge clk); #2;
      if (uip) uipSeen = 1'b1;
    end
    check("R9 frozen fields", dutVec(), held);
    check("R9 uip low in set mode", {63'd0, uipSeen}, 64'd0);

    // R10: divider stopped (value 4), no update
    @(negedge clk);
    setMode = 1'b0; divCtl = 3'd4;
    repeat (3 * TPS) @(posedge clk);
    #2;
    check("R10 stopped divider fields", dutVec(), held);

    // R10 R7 R8: divider reset, release, half-second start
    @(negedge clk);
    divCtl = 3'd6;
    repeat (5) @(posedge clk);
    pushSteps(1, "R10 first update after release");
    @(negedge clk);
    divCtl = 3'd2;
    for (int k = 1; k <= TPS / 2 + 1; k++) begin
      @(posedge clk); #2;
      if (k == TPS / 2 - UIPT - 1) check("R7 uip low before window", {63'd0, uip}, 64'd0);
      if (k == TPS / 2 - UIPT)     check("R7 uip high in window", {63'd0, uip}, 64'd1);
      if (k == TPS / 2 - 1)        check("R10 no update before half second", {63'd0, updEnd}, 64'd0);
      if (k == TPS / 2)            check("R10 R8 update at half second", {62'd0, updEnd, uip}, 64'd2);
      if (k == TPS / 2 + 1)        check("R8 pulse one cycle", {63'd0, updEnd}, 64'd0);
    end
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule